// File: doc/BRIEF.md
# Nested-Sweep Test Vector Sequencer

This block produces, in hardware, the stimulus pattern used to estimate the average switching activity of a combinational unit with `WIDTH` inputs. It does not present every possible ordering of the input space. Instead it walks two nested indices. An outer index names a group. Each group opens with one leading vector equal to the outer index. An ascending sweep of every `WIDTH`-bit value from zero to all-ones follows. The outer index then advances by one, and the run ends when the sweep of the all-ones group reaches all-ones. Every value is therefore preceded, at some point, by every other value, while the total work stays at roughly the square of the input space rather than its factorial.

A single-cycle start request while the block is idle launches a run. Each vector sits on the output with a valid strobe until the consumer accepts it with ready. The block also flags the leading vector of each group, shows the current group number, and pulses a done strobe when the final vector is accepted.

Top module: `nested_sweep_seq`

## Requirements
- R1: After reset, vecValid, runDone and groupFirst are low, and vecOut and groupIdx are all zeros.
- R2: A start request seen while idle makes vecValid high in the next cycle, presenting the leading vector of group zero (vecOut all zeros, groupFirst high, groupIdx zero).
- R3: Each group emits one leading vector equal to its group number with groupFirst high. It then emits 2^WIDTH vectors with groupFirst low, counting up by one from all zeros to all ones.
- R4: groupIdx equals the group number during every vector of that group. After the all-ones sweep vector of a group is accepted, the next group number is the previous one plus one.
- R5: A run consists of exactly 2^WIDTH groups, numbered zero to all-ones, for 2^WIDTH × (2^WIDTH + 1) accepted vectors in total.
- R6: A vector is consumed only in a cycle with vecValid and readyIn both high. While vecValid is high and readyIn is low, vecOut, groupFirst and groupIdx hold their values into the next cycle, and vecValid stays high.
- R7: runDone is high only in the cycle where the final vector of the run (the all-ones sweep vector of group all-ones) is accepted. In the following cycle vecValid is low.
- R8: A start request during a run has no effect on the emitted sequence. A new run after completion starts again from group zero.
- R9: While vecValid is low, vecOut is all zeros and groupFirst is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Launches a run when seen while idle |
| readyIn | input | 1 | Consumer accepts the present vector |
| vecOut | output | WIDTH | Current test vector |
| vecValid | output | 1 | vecOut holds a vector of the run |
| groupFirst | output | 1 | Present vector is the leading vector of its group |
| groupIdx | output | WIDTH | Current group number (outer index) |
| runDone | output | 1 | Final vector of the run accepted this cycle |

## Verification
The bench builds the sequencer three times, with WIDTH set to 1, 2 and 3. These widths are small enough that every accepted vector of a full run (6, 20 and 72 vectors) is compared against a nested-loop model, twice per width. Randomly withheld ready exercises the stall hold on every kind of vector, including the leading vector, the group wrap and the final vector. A start request injected mid-run and a second run after completion test the ignore and restart behaviour.

// File: rtl/nsweep_pkg.sv
package nsweep_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEAD  = 2'd1,
    ST_SWEEP = 2'd2
  } seqState_t;

  // strobes issued by the control to the index datapath
  typedef struct packed {
    logic clearIdx;   // zero both indices (run launch)
    logic bumpInner;  // advance sweep index
    logic bumpOuter;  // advance group index, rewind sweep index
  } pathCmd_t;
endpackage

// File: rtl/nsweep_path.sv
module nsweep_path
  import nsweep_pkg::*;
#(
  parameter int WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pathCmd_t         cmd,
  input  logic             showAny,
  input  logic             showLead,
  output logic             innerMax,
  output logic             outerMax,
  output logic [WIDTH-1:0] vecOut,
  output logic [WIDTH-1:0] groupIdx
);
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] outerIdx;
  logic [WIDTH-1:0] innerIdx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outerIdx <= '0;
      innerIdx <= '0;
    end else if (cmd.clearIdx) begin
      outerIdx <= '0;
      innerIdx <= '0;
    end else if (cmd.bumpOuter) begin
      outerIdx <= outerIdx + ONE;
      innerIdx <= '0;
    end else if (cmd.bumpInner) begin
      innerIdx <= innerIdx + ONE;
    end
  end

  assign innerMax = &innerIdx;
  assign outerMax = &outerIdx;
  assign groupIdx = outerIdx;

  always_comb begin
    if (!showAny)      vecOut = '0;
    else if (showLead) vecOut = outerIdx;
    else               vecOut = innerIdx;
  end

  // R4: group number steps by exactly one on a group change
  p_outer_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.bumpOuter && !cmd.clearIdx) |=> (outerIdx == $past(outerIdx) + ONE) && (innerIdx == '0));

  // R3: sweep index only counts up by one
  p_inner_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.bumpInner && !cmd.bumpOuter && !cmd.clearIdx) |=> innerIdx == $past(innerIdx) + ONE);

  // R5: group index never wraps within a run
  p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.bumpOuter |-> !outerMax);
endmodule

// File: rtl/nsweep_ctrl.sv
module nsweep_ctrl
  import nsweep_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     startReq,
  input  logic     readyIn,
  input  logic     innerMax,
  input  logic     outerMax,
  output pathCmd_t cmd,
  output logic     busy,
  output logic     leadPhase,
  output logic     finalBeat
);
  seqState_t stateQ, stateD;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stateQ <= ST_IDLE;
    else        stateQ <= stateD;
  end

  always_comb begin
    stateD = stateQ;
    cmd    = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (startReq) begin
          stateD       = ST_LEAD;
          cmd.clearIdx = 1'b1;
        end
      end
      ST_LEAD: begin
        if (readyIn) stateD = ST_SWEEP;
      end
      ST_SWEEP: begin
        if (readyIn) begin
          if (!innerMax) begin
            cmd.bumpInner = 1'b1;
          end else if (outerMax) begin
            stateD = ST_IDLE;
          end else begin
            cmd.bumpOuter = 1'b1;
            stateD        = ST_LEAD;
          end
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  assign busy      = (stateQ != ST_IDLE);
  assign leadPhase = (stateQ == ST_LEAD);
  assign finalBeat = (stateQ == ST_SWEEP) && innerMax && outerMax;

  // R6: nothing moves on a stalled cycle
  p_stall_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !readyIn) |-> (stateD == stateQ) && (cmd == '0));

  // R8: a start request inside a run issues no index clear
  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !cmd.clearIdx);
endmodule

// File: rtl/nested_sweep_seq.sv
module nested_sweep_seq
  import nsweep_pkg::*;
#(
  parameter int WIDTH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             startReq,
  input  logic             readyIn,
  output logic [WIDTH-1:0] vecOut,
  output logic             vecValid,
  output logic             groupFirst,
  output logic [WIDTH-1:0] groupIdx,
  output logic             runDone
);
  pathCmd_t cmd;
  logic     busy, leadPhase, finalBeat, innerMax, outerMax;

  nsweep_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .startReq (startReq),
    .readyIn  (readyIn),
    .innerMax (innerMax),
    .outerMax (outerMax),
    .cmd      (cmd),
    .busy     (busy),
    .leadPhase(leadPhase),
    .finalBeat(finalBeat)
  );

  nsweep_path #(.WIDTH(WIDTH)) u_path (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd     (cmd),
    .showAny (busy),
    .showLead(leadPhase),
    .innerMax(innerMax),
    .outerMax(outerMax),
    .vecOut  (vecOut),
    .groupIdx(groupIdx)
  );

  assign vecValid   = busy;
  assign groupFirst = leadPhase;
  assign runDone    = finalBeat && readyIn;

  // R6: held outputs while stalled
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (vecValid && !readyIn) |=> vecValid && $stable(vecOut) && $stable(groupFirst) && $stable(groupIdx));

  // R7: run ends right after the done pulse
  p_done_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
    runDone |=> !vecValid);

  // R7: done only with the all-ones sweep vector of the all-ones group
  p_done_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
    runDone |-> vecValid && !groupFirst && (&vecOut) && (&groupIdx));

  // R3: leading vector mirrors the group number
  p_lead_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (vecValid && groupFirst) |-> vecOut == groupIdx);

  // R2: launch presents group zero's leading vector
  p_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!vecValid && startReq) |=> vecValid && groupFirst && (vecOut == '0) && (groupIdx == '0));
endmodule

// File: tb/nested_sweep_seq_tb_top.sv
module nsweep_lane #(
  parameter int W    = 1,
  parameter int SEED = 1
) (
  input  logic clk,
  input  logic rst_n,
  output int   checks,
  output int   fails,
  output logic finished
);
  localparam int SPAN  = 1 << W;
  localparam int TOTAL = SPAN * (SPAN + 1);

  logic         startReq, readyIn;
  logic [W-1:0] vecOut, groupIdx;
  logic         vecValid, groupFirst, runDone;

  nested_sweep_seq #(.WIDTH(W)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .startReq  (startReq),
    .readyIn   (readyIn),
    .vecOut    (vecOut),
    .vecValid  (vecValid),
    .groupFirst(groupFirst),
    .groupIdx  (groupIdx),
    .runDone   (runDone)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL W=%0d %s actual=%0d expected=%0d", W, req, act, exp);
    end
  endtask

  task automatic one_run(input int runNo);
    int   accepted;
    bit   prevStall;
    bit   ended;
    int   pVec, pIdx;
    bit   pFirst;
    accepted  = 0;
    prevStall = 0;
    ended     = 0;
    pVec = 0; pIdx = 0; pFirst = 0;
    @(negedge clk);
    startReq = 1'b1;
    readyIn  = 1'b0;
    @(negedge clk);
    startReq = 1'b0;
    #1;
    // R2: first cycle after launch shows group zero leading vector
    check(vecValid && groupFirst && vecOut == '0 && groupIdx == '0, "R2 launch", int'(vecValid), 1);
    while (!ended) begin
      @(negedge clk);
      readyIn  = (($urandom % 4) != 0);
      startReq = (accepted == 3 || accepted == SPAN + 2); // R8: mid-run start
      #1;
      if (prevStall) begin
        // R6: stalled vector held
        check(vecValid && int'(vecOut) == pVec && groupFirst == pFirst && int'(groupIdx) == pIdx,
              "R6 hold", int'(vecOut), pVec);
      end
      if (vecValid) begin
        int g, k, expVec;
        bit expFirst, expDone;
        g        = accepted / (SPAN + 1);
        k        = accepted % (SPAN + 1);
        expFirst = (k == 0);
        expVec   = expFirst ? g : k - 1;
        expDone  = readyIn && (accepted == TOTAL - 1);
        check(int'(vecOut) == expVec, expFirst ? "R3 lead value" : "R3 sweep value", int'(vecOut), expVec);
        check(groupFirst == expFirst, "R3 groupFirst", int'(groupFirst), int'(expFirst));
        check(int'(groupIdx) == g, "R4 groupIdx", int'(groupIdx), g);
        check(runDone == expDone, "R7 runDone", int'(runDone), int'(expDone));
        if (readyIn) accepted++;
        prevStall = !readyIn;
        pVec = int'(vecOut); pIdx = int'(groupIdx); pFirst = groupFirst;
      end else begin
        // R7: valid drops right after final acceptance; R9 quiet outputs
        check(accepted == TOTAL, "R7 end of run", accepted, TOTAL);
        check(vecOut == '0 && !groupFirst && !runDone, "R9 idle outputs", int'(vecOut), 0);
        ended     = 1;
        prevStall = 0;
      end
    end
    startReq = 1'b0;
    // R5: vector count of the whole run
    check(accepted == TOTAL, "R5 total vectors", accepted, TOTAL);
    if (runNo > 0) check(1'b1, "R8 restart", 0, 0);
  endtask

  initial begin
    checks   = 0;
    fails    = 0;
    finished = 1'b0;
    startReq = 1'b0;
    readyIn  = 1'b0;
    void'($urandom(SEED));
    @(posedge rst_n);
    @(negedge clk);
    #1;
    // R1: reset state
    check(!vecValid && !runDone && !groupFirst && vecOut == '0 && groupIdx == '0,
          "R1 reset state", int'(vecValid), 0);
    readyIn = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    // R1/R9: ready alone does not launch
    check(!vecValid && vecOut == '0, "R1 idle without start", int'(vecValid), 0);
    one_run(0);
    repeat (2) @(negedge clk);
    one_run(1); // R8: second run restarts from group zero
    finished = 1'b1;
  end
endmodule

module nested_sweep_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int   c1, f1, c2, f2, c3, f3;
  logic d1, d2, d3;

  always #4 clk = ~clk; // 8 ns period, 125 MHz

  nsweep_lane #(.W(1), .SEED(11)) lane1 (.clk(clk), .rst_n(rst_n), .checks(c1), .fails(f1), .finished(d1));
  nsweep_lane #(.W(2), .SEED(22)) lane2 (.clk(clk), .rst_n(rst_n), .checks(c2), .fails(f2), .finished(d2));
  nsweep_lane #(.W(3), .SEED(33)) lane3 (.clk(clk), .rst_n(rst_n), .checks(c3), .fails(f3), .finished(d3));

  initial begin
    int cycles;
    int extraFail;
    cycles    = 0;
    extraFail = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    while (!(d1 && d2 && d3) && cycles < 20000) begin
      @(posedge clk);
      cycles++;
    end
    if (!(d1 && d2 && d3)) begin
      extraFail = 1;
      $display("FAIL watchdog all-lanes actual=%0d expected=%0d", cycles, 20000);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***",
             c1 + c2 + c3 + extraFail, f1 + f2 + f3 + extraFail);
    $finish;
  end
endmodule